// File: doc/BRIEF.md
# Audio Stream Enable Gate

This block sits beside one audio converter and decides, frame by frame, whether that converter's stream manager takes part in link traffic. The manager runs only when three conditions hold together: a non-zero stream number is programmed, the converter is at full power, and, for a digital converter, its digital enable is set. A capture converter then places its samples on the link. A render converter accepts only the link slots whose tag equals its stream number and forwards their samples to the converter.

The active flag follows the enable conditions only on cycles that carry the frame-sync strobe. A stream therefore always starts and stops on a frame boundary. Mute forces the samples to zero but leaves the stream running. A local test path reaches the render output whether or not the gate is open.

While the stream runs, the stream format register is locked. A write to it is dropped and raises a sticky flag. The stream number register can be written at any time, and writing zero is the normal way to stop a stream.

Top module: `stream_gate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `active`, `sid_q`, `fmt_q` and `fmt_wr_blocked` are all zero.
- R2: `active` changes only at a rising clock edge where `frame_sync` is high. At that edge it takes the value of the enable condition, evaluated with the register values held before the edge.
- R3: If `sid_q` is zero at a frame-sync edge, `active` is low after that edge. Writing a non-zero value and then reaching a frame-sync edge starts the stream, provided the other conditions hold.
- R4: Power state encoding on `pwr_state` is 0=D0, 1=D1, 2=D2, 3=D3. Any value other than 0 at a frame-sync edge leaves `active` low after that edge.
- R5: When `IS_DIGITAL` is 1, `dig_en` low at a frame-sync edge leaves `active` low after that edge.
- R6: For a render converter (`IS_CAPTURE`=0), `rnd_dec_en` is high only when `active`, `link_valid` and `link_tag` equals `sid_q` all hold, with `link_tag` non-zero. Tag 0 is never decoded. When `test_sel` is low and mute is off, `rnd_out_data` equals `link_data` while decoding and is zero otherwise. A capture converter never decodes.
- R7: For a capture converter (`IS_CAPTURE`=1), `cap_tx_en` equals `active`, and `cap_tx_data` equals `cap_data` while enabled and unmuted, and zero otherwise. A render converter never transmits.
- R8: While `mute` is high, `cap_tx_data` is zero and, unless `test_sel` is high, `rnd_out_data` is zero. `active` is not affected by mute.
- R9: While `test_sel` is high, `rnd_out_data` equals `test_data`, regardless of the active flag, mute or the link.
- R10: A `fmt_wr_en` pulse while `active` is low loads `fmt_wr_data` into `fmt_q` on the next cycle. While `active` is high, the write is ignored and `fmt_wr_blocked` becomes 1 and stays 1 until reset.
- R11: A `sid_wr_en` pulse loads `sid_wr_data` into `sid_q` on the next cycle, whatever the state of `active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame boundary strobe |
| sid_wr_en | input | 1 | Stream number write strobe |
| sid_wr_data | input | SID_W | Stream number write value |
| fmt_wr_en | input | 1 | Format register write strobe |
| fmt_wr_data | input | FMT_W | Format register write value |
| pwr_state | input | 2 | Converter power state (0=D0 .. 3=D3) |
| dig_en | input | 1 | Digital converter enable |
| mute | input | 1 | Sample mute |
| link_valid | input | 1 | Link slot valid |
| link_tag | input | SID_W | Stream tag of the current link slot |
| link_data | input | DATA_W | Sample carried by the link slot |
| cap_data | input | DATA_W | Converter sample to be captured |
| test_sel | input | 1 | Select local test path |
| test_data | input | DATA_W | Local test path sample |
| active | output | 1 | Stream manager running |
| cap_tx_en | output | 1 | Capture sample is placed on link |
| cap_tx_data | output | DATA_W | Capture sample toward link |
| rnd_dec_en | output | 1 | Current link slot is decoded |
| rnd_out_data | output | DATA_W | Render sample toward converter |
| sid_q | output | SID_W | Current stream number |
| fmt_q | output | FMT_W | Current format register |
| fmt_wr_blocked | output | 1 | Sticky flag for a format write refused while active |

## Verification
The assertions check on every cycle the following:
- `active` holds between frame strobes, and each stop condition clears it at a strobe.
- Mute and the test bypass act on the sample outputs.
- Decode and transmit never occur without `active`.
- A format write during a running stream leaves `fmt_q` untouched.

The scenarios are needed to show that streams actually start after the right strobe and that only matching tags are decoded. They also show that a stream-number write arriving on the same edge as a strobe is taken into account only at the next strobe, and that the sticky flag survives later activity.

// File: rtl/stream_gate_pkg.sv
package stream_gate_pkg;

    typedef enum logic [1:0] {
        PWR_D0 = 2'd0,
        PWR_D1 = 2'd1,
        PWR_D2 = 2'd2,
        PWR_D3 = 2'd3
    } pwr_e;

    typedef struct packed {
        logic sid_nz;
        logic full_pwr;
        logic dig_ok;
    } enable_cond_t;

    typedef struct packed {
        logic cap_en;
        logic dec_en;
    } gate_en_t;

    function automatic enable_cond_t make_cond(input logic sid_nz,
                                               input logic [1:0] pwr,
                                               input logic dig_en,
                                               input logic need_dig);
        enable_cond_t c;
        c.sid_nz   = sid_nz;
        c.full_pwr = (pwr == PWR_D0);
        c.dig_ok   = dig_en | ~need_dig;
        return c;
    endfunction

    function automatic logic cond_met(input enable_cond_t c);
        return c.sid_nz & c.full_pwr & c.dig_ok;
    endfunction

endpackage

// File: rtl/sg_cfg_regs.sv
module sg_cfg_regs
    import stream_gate_pkg::*;
#(
    parameter int SID_W = 4,
    parameter int FMT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             sid_wr_en,
    input  logic [SID_W-1:0] sid_wr_data,
    input  logic             fmt_wr_en,
    input  logic [FMT_W-1:0] fmt_wr_data,
    output logic [SID_W-1:0] sid_q,
    output logic [FMT_W-1:0] fmt_q,
    output logic             fmt_blocked
);

    logic fmt_accept;
    logic fmt_refuse;

    assign fmt_accept = fmt_wr_en & ~active;
    assign fmt_refuse = fmt_wr_en &  active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sid_q <= '0;
        end else if (sid_wr_en) begin
            sid_q <= sid_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q       <= '0;
            fmt_blocked <= 1'b0;
        end else begin
            if (fmt_accept) begin
                fmt_q <= fmt_wr_data;
            end
            if (fmt_refuse) begin
                fmt_blocked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sg_enable_ctrl.sv
module sg_enable_ctrl
    import stream_gate_pkg::*;
#(
    parameter int SID_W      = 4,
    parameter bit IS_DIGITAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_sync,
    input  logic [SID_W-1:0] sid_q,
    input  logic [1:0]       pwr_state,
    input  logic             dig_en,
    output logic             active
);

    localparam logic NEED_DIG = IS_DIGITAL;

    enable_cond_t cond;
    logic         want;

    always_comb begin
        cond = make_cond(|sid_q, pwr_state, dig_en, NEED_DIG);
        want = cond_met(cond);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (frame_sync) begin
            active <= want;
        end
    end

endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
    import stream_gate_pkg::*;
#(
    parameter int SID_W      = 4,
    parameter int DATA_W     = 24,
    parameter bit IS_CAPTURE = 1'b0
) (
    input  logic              active,
    input  logic [SID_W-1:0]  sid_q,
    input  logic              mute,
    input  logic              link_valid,
    input  logic [SID_W-1:0]  link_tag,
    input  logic [DATA_W-1:0] link_data,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              test_sel,
    input  logic [DATA_W-1:0] test_data,
    output gate_en_t          en,
    output logic [DATA_W-1:0] cap_tx_data,
    output logic [DATA_W-1:0] rnd_out_data
);

    localparam logic CAP_KIND = IS_CAPTURE;
    localparam logic RND_KIND = !IS_CAPTURE;

    logic tag_hit;
    logic [DATA_W-1:0] link_sample;

    assign tag_hit = link_valid && (link_tag == sid_q) && (link_tag != '0);

    always_comb begin
        en.cap_en = active & CAP_KIND;
        en.dec_en = active & RND_KIND & tag_hit;
    end

    always_comb begin
        cap_tx_data = (en.cap_en && !mute) ? cap_data : '0;
        link_sample = (en.dec_en && !mute) ? link_data : '0;
        rnd_out_data = test_sel ? test_data : link_sample;
    end

endmodule

// File: rtl/stream_gate.sv
module stream_gate
    import stream_gate_pkg::*;
#(
    parameter int SID_W      = 4,
    parameter int FMT_W      = 16,
    parameter int DATA_W     = 24,
    parameter bit IS_CAPTURE = 1'b0,
    parameter bit IS_DIGITAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic              sid_wr_en,
    input  logic [SID_W-1:0]  sid_wr_data,
    input  logic              fmt_wr_en,
    input  logic [FMT_W-1:0]  fmt_wr_data,
    input  logic [1:0]        pwr_state,
    input  logic              dig_en,
    input  logic              mute,
    input  logic              link_valid,
    input  logic [SID_W-1:0]  link_tag,
    input  logic [DATA_W-1:0] link_data,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              test_sel,
    input  logic [DATA_W-1:0] test_data,
    output logic              active,
    output logic              cap_tx_en,
    output logic [DATA_W-1:0] cap_tx_data,
    output logic              rnd_dec_en,
    output logic [DATA_W-1:0] rnd_out_data,
    output logic [SID_W-1:0]  sid_q,
    output logic [FMT_W-1:0]  fmt_q,
    output logic              fmt_wr_blocked
);

    gate_en_t en;

    sg_cfg_regs #(.SID_W(SID_W), .FMT_W(FMT_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .sid_wr_en   (sid_wr_en),
        .sid_wr_data (sid_wr_data),
        .fmt_wr_en   (fmt_wr_en),
        .fmt_wr_data (fmt_wr_data),
        .sid_q       (sid_q),
        .fmt_q       (fmt_q),
        .fmt_blocked (fmt_wr_blocked)
    );

    sg_enable_ctrl #(.SID_W(SID_W), .IS_DIGITAL(IS_DIGITAL)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .sid_q      (sid_q),
        .pwr_state  (pwr_state),
        .dig_en     (dig_en),
        .active     (active)
    );

    sg_datapath #(.SID_W(SID_W), .DATA_W(DATA_W), .IS_CAPTURE(IS_CAPTURE)) u_dp (
        .active       (active),
        .sid_q        (sid_q),
        .mute         (mute),
        .link_valid   (link_valid),
        .link_tag     (link_tag),
        .link_data    (link_data),
        .cap_data     (cap_data),
        .test_sel     (test_sel),
        .test_data    (test_data),
        .en           (en),
        .cap_tx_data  (cap_tx_data),
        .rnd_out_data (rnd_out_data)
    );

    assign cap_tx_en  = en.cap_en;
    assign rnd_dec_en = en.dec_en;

endmodule

// File: rtl/stream_gate_chk.sv
module stream_gate_chk #(
    parameter int SID_W      = 4,
    parameter int FMT_W      = 16,
    parameter int DATA_W     = 24,
    parameter bit IS_DIGITAL = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_sync,
    input logic              sid_wr_en,
    input logic [SID_W-1:0]  sid_wr_data,
    input logic              fmt_wr_en,
    input logic [1:0]        pwr_state,
    input logic              dig_en,
    input logic              mute,
    input logic              test_sel,
    input logic [DATA_W-1:0] test_data,
    input logic              active,
    input logic              cap_tx_en,
    input logic [DATA_W-1:0] cap_tx_data,
    input logic              rnd_dec_en,
    input logic [DATA_W-1:0] rnd_out_data,
    input logic [SID_W-1:0]  sid_q,
    input logic [FMT_W-1:0]  fmt_q,
    input logic              fmt_wr_blocked
);

    localparam logic NEED_DIG = IS_DIGITAL;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!active && sid_q == '0 && fmt_q == '0 && !fmt_wr_blocked));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> $stable(active));

    p_stop_sid_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && sid_q == '0) |=> !active);

    p_stop_pwr_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && pwr_state != 2'd0) |=> !active);

    p_stop_dig_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !dig_en && NEED_DIG) |=> !active);

    p_dec_needs_active_r6: assert property (@(posedge clk) disable iff (rst)
        rnd_dec_en |-> (active && sid_q != '0));

    p_tx_needs_active_r7: assert property (@(posedge clk) disable iff (rst)
        cap_tx_en |-> active);

    p_mute_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (mute && !test_sel) |-> (rnd_out_data == '0 && cap_tx_data == '0));

    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        test_sel |-> (rnd_out_data == test_data));

    p_fmt_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (fmt_wr_en && active) |=> (fmt_wr_blocked && $stable(fmt_q)));

    p_sid_load_r11: assert property (@(posedge clk) disable iff (rst)
        sid_wr_en |=> (sid_q == $past(sid_wr_data)));

endmodule

bind stream_gate stream_gate_chk #(
    .SID_W(SID_W), .FMT_W(FMT_W), .DATA_W(DATA_W), .IS_DIGITAL(IS_DIGITAL)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .frame_sync     (frame_sync),
    .sid_wr_en      (sid_wr_en),
    .sid_wr_data    (sid_wr_data),
    .fmt_wr_en      (fmt_wr_en),
    .pwr_state      (pwr_state),
    .dig_en         (dig_en),
    .mute           (mute),
    .test_sel       (test_sel),
    .test_data      (test_data),
    .active         (active),
    .cap_tx_en      (cap_tx_en),
    .cap_tx_data    (cap_tx_data),
    .rnd_dec_en     (rnd_dec_en),
    .rnd_out_data   (rnd_out_data),
    .sid_q          (sid_q),
    .fmt_q          (fmt_q),
    .fmt_wr_blocked (fmt_wr_blocked)
);

// File: tb/tb_stream_gate.sv
module tb_stream_gate;

    localparam int SID_W  = 4;
    localparam int FMT_W  = 16;
    localparam int DATA_W = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_sync = 1'b0;
    logic              sid_wr_en = 1'b0;
    logic [SID_W-1:0]  sid_wr_data = '0;
    logic              fmt_wr_en = 1'b0;
    logic [FMT_W-1:0]  fmt_wr_data = '0;
    logic [1:0]        pwr_state = 2'd0;
    logic              dig_en = 1'b1;
    logic              mute = 1'b0;
    logic              link_valid = 1'b0;
    logic [SID_W-1:0]  link_tag = '0;
    logic [DATA_W-1:0] link_data = '0;
    logic [DATA_W-1:0] cap_data = '0;
    logic              test_sel = 1'b0;
    logic [DATA_W-1:0] test_data = '0;

    logic              r_active, r_cap_en, r_dec_en, r_blk;
    logic [DATA_W-1:0] r_cap_d, r_rnd_d;
    logic [SID_W-1:0]  r_sid;
    logic [FMT_W-1:0]  r_fmt;
    logic              c_active, c_cap_en, c_dec_en, c_blk;
    logic [DATA_W-1:0] c_cap_d, c_rnd_d;
    logic [SID_W-1:0]  c_sid;
    logic [FMT_W-1:0]  c_fmt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural model state
    int m_sid = 0, m_fmt = 0, m_act = 0, m_blk = 0;

    always #5 clk = ~clk;

    stream_gate #(.SID_W(SID_W), .FMT_W(FMT_W), .DATA_W(DATA_W),
                  .IS_CAPTURE(1'b0), .IS_DIGITAL(1'b1)) dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync),
        .sid_wr_en(sid_wr_en), .sid_wr_data(sid_wr_data),
        .fmt_wr_en(fmt_wr_en), .fmt_wr_data(fmt_wr_data),
        .pwr_state(pwr_state), .dig_en(dig_en), .mute(mute),
        .link_valid(link_valid), .link_tag(link_tag), .link_data(link_data),
        .cap_data(cap_data), .test_sel(test_sel), .test_data(test_data),
        .active(r_active), .cap_tx_en(r_cap_en), .cap_tx_data(r_cap_d),
        .rnd_dec_en(r_dec_en), .rnd_out_data(r_rnd_d),
        .sid_q(r_sid), .fmt_q(r_fmt), .fmt_wr_blocked(r_blk));

    stream_gate #(.SID_W(SID_W), .FMT_W(FMT_W), .DATA_W(DATA_W),
                  .IS_CAPTURE(1'b1), .IS_DIGITAL(1'b1)) dut_cap (
        .clk(clk), .rst(rst), .frame_sync(frame_sync),
        .sid_wr_en(sid_wr_en), .sid_wr_data(sid_wr_data),
        .fmt_wr_en(fmt_wr_en), .fmt_wr_data(fmt_wr_data),
        .pwr_state(pwr_state), .dig_en(dig_en), .mute(mute),
        .link_valid(link_valid), .link_tag(link_tag), .link_data(link_data),
        .cap_data(cap_data), .test_sel(test_sel), .test_data(test_data),
        .active(c_active), .cap_tx_en(c_cap_en), .cap_tx_data(c_cap_d),
        .rnd_dec_en(c_dec_en), .rnd_out_data(c_rnd_d),
        .sid_q(c_sid), .fmt_q(c_fmt), .fmt_wr_blocked(c_blk));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // model update at each active edge, using values held before the edge
    always @(posedge clk) begin
        int n_act, n_fmt, n_blk, n_sid;
        if (rst) begin
            m_sid = 0; m_fmt = 0; m_act = 0; m_blk = 0;
        end else begin
            n_act = m_act; n_fmt = m_fmt; n_blk = m_blk; n_sid = m_sid;
            if (frame_sync)
                n_act = (m_sid != 0 && pwr_state == 2'd0 && dig_en) ? 1 : 0;
            if (fmt_wr_en) begin
                if (m_act != 0) n_blk = 1;
                else            n_fmt = int'(fmt_wr_data);
            end
            if (sid_wr_en) n_sid = int'(sid_wr_data);
            m_act = n_act; m_fmt = n_fmt; m_blk = n_blk; m_sid = n_sid;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit exp_dec;
        longint exp_rnd, exp_cap, exp_crnd;
        if (!rst && !done) begin
            exp_dec  = (m_act != 0) && link_valid && (int'(link_tag) == m_sid) && (link_tag != 0);
            exp_rnd  = test_sel ? longint'(test_data) : ((exp_dec && !mute) ? longint'(link_data) : 0);
            exp_cap  = (m_act != 0 && !mute) ? longint'(cap_data) : 0;
            exp_crnd = test_sel ? longint'(test_data) : 0;
            check(r_active == m_act[0] && m_act < 2, "R2 render active", r_active, m_act);
            check(c_active == m_act[0], "R2 capture active", c_active, m_act);
            check(int'(r_sid) == m_sid, "R11 sid_q", r_sid, m_sid);
            check(int'(r_fmt) == m_fmt, "R10 fmt_q", r_fmt, m_fmt);
            check(r_blk == m_blk[0], "R10 blocked flag", r_blk, m_blk);
            check(c_blk == m_blk[0], "R10 blocked flag capture", c_blk, m_blk);
            check(r_dec_en == exp_dec, "R6 render decode", r_dec_en, exp_dec);
            check(c_dec_en == 1'b0, "R6 capture never decodes", c_dec_en, 0);
            check(r_cap_en == 1'b0, "R7 render never transmits", r_cap_en, 0);
            check(c_cap_en == m_act[0], "R7 capture transmit", c_cap_en, m_act);
            check(longint'(r_rnd_d) == exp_rnd,
                  test_sel ? "R9 render bypass" : (mute ? "R8 render mute" : "R6 render data"),
                  r_rnd_d, exp_rnd);
            check(longint'(c_cap_d) == exp_cap, mute ? "R8 capture mute" : "R7 capture data",
                  c_cap_d, exp_cap);
            check(longint'(c_rnd_d) == exp_crnd, "R9 capture bypass", c_rnd_d, exp_crnd);
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_sid(input int v);
        sid_wr_en = 1'b1; sid_wr_data = SID_W'(v);
        cyc();
        sid_wr_en = 1'b0;
    endtask

    task automatic wr_fmt(input int v);
        fmt_wr_en = 1'b1; fmt_wr_data = FMT_W'(v);
        cyc();
        fmt_wr_en = 1'b0;
    endtask

    task automatic fsync();
        frame_sync = 1'b1;
        cyc();
        frame_sync = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cyc(3);
        // R1: reset state observed while held
        check(!r_active && r_sid == 0 && r_fmt == 0 && !r_blk, "R1 reset state", r_active, 0);
        rst = 1'b0;
        cyc();
        check(!r_active && !c_active && r_sid == 0, "R1 after reset", r_active, 0);

        // R10: format write while idle is taken
        wr_fmt(16'h1234);
        check(r_fmt == 16'h1234 && !r_blk, "R10 idle format write", r_fmt, 16'h1234);

        // R2: stream number alone does not start without a strobe
        wr_sid(5);
        check(r_sid == 5, "R11 sid write", r_sid, 5);
        cyc(3);
        check(!r_active, "R2 no start without frame sync", r_active, 0);
        fsync();
        check(r_active && c_active, "R2 start on frame sync", r_active, 1);

        // R6: tag matching
        link_valid = 1'b1; link_tag = 4'd5; link_data = 24'hABCDEF; cap_data = 24'h123456;
        cyc();
        check(r_dec_en && r_rnd_d == 24'hABCDEF, "R6 matching tag decoded", r_rnd_d, 24'hABCDEF);
        check(c_cap_d == 24'h123456, "R7 capture sample on link", c_cap_d, 24'h123456);
        link_tag = 4'd3;
        cyc();
        check(!r_dec_en && r_rnd_d == 0, "R6 other tag ignored", r_rnd_d, 0);
        link_tag = 4'd5;

        // R8: mute zeros samples, stream keeps running
        mute = 1'b1;
        cyc(2);
        check(r_active && r_rnd_d == 0 && c_cap_d == 0, "R8 mute zeroes data", r_rnd_d, 0);
        fsync();
        check(r_active, "R8 mute keeps stream", r_active, 1);

        // R9: bypass while muted and active
        test_sel = 1'b1; test_data = 24'h0F0F0F;
        cyc();
        check(r_rnd_d == 24'h0F0F0F, "R9 bypass while muted", r_rnd_d, 24'h0F0F0F);
        mute = 1'b0; test_sel = 1'b0;

        // R10: format write while active refused
        wr_fmt(16'hBEEF);
        check(r_fmt == 16'h1234 && r_blk, "R10 active format write ignored", r_fmt, 16'h1234);

        // R4: low-power states stop only at frame sync
        pwr_state = 2'd3;
        cyc(2);
        check(r_active, "R4 no stop before frame sync", r_active, 1);
        fsync();
        check(!r_active && !c_cap_en, "R4 D3 stops stream", r_active, 0);
        pwr_state = 2'd1;
        fsync();
        check(!r_active, "R4 D1 keeps stream stopped", r_active, 0);
        test_sel = 1'b1; test_data = 24'h00AA55;
        cyc();
        check(r_rnd_d == 24'h00AA55, "R9 bypass while inactive", r_rnd_d, 24'h00AA55);
        test_sel = 1'b0;
        pwr_state = 2'd2;
        fsync();
        check(!r_active, "R4 D2 keeps stream stopped", r_active, 0);
        pwr_state = 2'd0;
        fsync();
        check(r_active, "R4 D0 restarts", r_active, 1);

        // R5: digital enable
        dig_en = 1'b0;
        fsync();
        check(!r_active, "R5 digital enable low stops", r_active, 0);
        dig_en = 1'b1;
        fsync();
        check(r_active, "R5 digital enable high restarts", r_active, 1);

        // R3: writing zero stops at the next strobe; tag 0 never decoded
        wr_sid(0);
        link_tag = 4'd0;
        cyc();
        check(r_active && !r_dec_en, "R3 tag zero not decoded", r_dec_en, 0);
        fsync();
        check(!r_active, "R3 zero stream number stops", r_active, 0);

        // R2/R11: write coinciding with strobe uses the old value
        sid_wr_en = 1'b1; sid_wr_data = 4'd2; frame_sync = 1'b1;
        cyc();
        sid_wr_en = 1'b0; frame_sync = 1'b0;
        check(!r_active && r_sid == 2, "R2 strobe sees old stream number", r_active, 0);
        fsync();
        check(r_active, "R3 nonzero stream number starts", r_active, 1);
        check(r_blk, "R10 blocked flag sticky", r_blk, 1);

        // mixed pattern, compared against the model every cycle
        for (int k = 0; k < 400; k++) begin
            int h;
            h = (k * 37 + 11) ^ (k >> 2);
            frame_sync  = (k % 5 == 0);
            sid_wr_en   = (h % 23 == 0);
            sid_wr_data = SID_W'(h >> 3);
            fmt_wr_en   = (h % 13 == 0);
            fmt_wr_data = FMT_W'(h * 7);
            pwr_state   = (h % 17 == 0) ? 2'(h >> 1) : 2'd0;
            dig_en      = (h % 19 != 0);
            mute        = (h % 11 == 0);
            link_valid  = h[0];
            link_tag    = SID_W'(k % 4);
            link_data   = DATA_W'(h * 131);
            cap_data    = DATA_W'(h * 97);
            test_sel    = (h % 29 == 0);
            test_data   = DATA_W'(h * 3);
            cyc();
        end
        frame_sync = 1'b0; sid_wr_en = 1'b0; fmt_wr_en = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule